// File: doc/BRIEF.md
# Processor Reset Sequencer

This block turns the raw, asynchronous, active-high reset pin of a processor core into the core's internal start-up control. It brings the pin into the clock domain through a chain of flops. It stops the core and floats the bus while the pin is high, and it measures how long the pin stayed high. Once a pin pulse that was long enough has ended, the block runs a fixed count of internal sequence cycles. It then releases the core with a one-cycle start pulse that carries the 20-bit reset fetch address.

While the core is held, the block drives the bus pins to their reset levels. Status keeps being driven for one clock after the halt begins and then floats. The other three-state groups float, and the address-latch strobe and the hold acknowledge are both held low. The acknowledge is the exception when a hold is granted before the first fetch. The block also tells the interrupt logic when a non-maskable request may be accepted. That window stays shut until the second clock after the internal sequence has started.

After the block's own synchronous reset, it behaves as if a valid pin pulse has just been seen. If the pin is already low, the full start-up sequence runs without any further stimulus.

Top module: `rst_sequencer`

## Requirements
- R1: The pin passes through a two-flop synchronizer, so a change on `reset_pin` set up before clock edge k shows on `core_halt` after edge k+2.
- R2: While the synchronized pin is high, `core_halt`=1, `bus_oe`=0, `ale_low`=1 and `start`=0.
- R3: A synchronized high pulse of 4 clocks or fewer is ignored. A core that was running resumes (`core_halt`=0) in the first cycle the synchronized pin is low, with no sequence and no `start`.
- R4: After a synchronized high pulse of 5 clocks or more, the block stays halted for exactly SEQ_CYCLES (10) cycles after the synchronized pin falls, and then releases the core.
- R5: `start` is high for exactly one cycle, the first cycle after release. `fetch_addr` is 20'hFFFF0 in that cycle and 0 in every other cycle.
- R6: In the first cycle of a halt entered from normal running, `status_oe` stays 1. It is 0 for the rest of the halt, the sequence and any hold.
- R7: `nmi_ok` is 0 while the pin is held and in the first 2 cycles of the sequence. It is 1 from the third sequence cycle onward, in hold and in normal running.
- R8: If `hold_req` is high in the last sequence cycle, the block enters a hold state with `hlda`=1 and bus floated. It releases the core, with `start`, in the cycle after `hold_req` is seen low.
- R9: A pin pulse during the sequence or the hold, whether short or valid, returns the block to halt. The full sequence then restarts when the pulse ends.
- R10: After `rst_n`, the block is halted with a valid pulse already counted. If `reset_pin` is low, it starts the sequence once the synchronizer shows the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reset_pin | input | 1 | Asynchronous active-high reset pin |
| hold_req | input | 1 | Bus hold request, synchronous to clk |
| core_halt | output | 1 | Keeps the core dormant |
| start | output | 1 | One-cycle release pulse |
| fetch_addr | output | 20 | Reset fetch address, valid with start |
| status_oe | output | 1 | Drive enable for the status pins |
| bus_oe | output | 1 | Drive enable for the other three-state pins |
| ale_low | output | 1 | Forces the address-latch strobe low |
| hlda | output | 1 | Hold acknowledge |
| nmi_ok | output | 1 | The non-maskable interrupt may be latched |

## Verification
A wrong pulse-width count shows up at release. Either a short pulse produces a `start` and a ten-cycle delay, or a valid pulse resumes the core at once, and both appear within one clock of the synchronized pin falling. A wrong sequence count moves `start` and the rise of `nmi_ok` by the error, so the per-clock comparison flags it in the cycle it first differs. A wrong state after a pulse during the sequence or the hold surfaces as an early release or a missing `hlda` on the next edges.

// File: rtl/rst_seq_pkg.sv
// Shared types of the reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rst_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_SEQ  = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rst_seq_sync.sv
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes: rst_n is synchronous and the flops reset to RST_VAL.
module rst_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later flops settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_width.sv
// Counts the clocks the synchronized pin stays high and flags a valid pulse.
// Assumes: clear is asserted in the cycle the pulse is first seen.
module rst_seq_width #(
    parameter int MIN_HIGH = 4,
    localparam int CW = $clog2(MIN_HIGH + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic first,
    input  logic count,
    output logic valid,
    output logic first_cycle
);
    localparam logic [CW-1:0] SAT = CW'(MIN_HIGH + 1);
    logic [CW-1:0] cnt;

    // Saturating count of high cycles; a reset starts at the valid level.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= SAT;
        else if (first)             cnt <= CW'(1);
        else if (count && cnt != SAT) cnt <= cnt + CW'(1);
    end

    assign valid       = (cnt == SAT);
    assign first_cycle = (cnt == CW'(1));
endmodule

// File: rtl/rst_seq_fsm.sv
// Control state: run, halt, internal sequence and hold before first fetch.
// Assumes: pin_s is already synchronized; hold_req is synchronous to clk.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int SEQ_CYCLES = 10,
    parameter int NMI_OPEN   = 2,
    localparam int SW = $clog2(SEQ_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic       pulse_valid,
    input  logic       hold_req,
    output seq_state_t state,
    output logic       pulse_first,
    output logic       pulse_count,
    output logic       start_q,
    output logic       nmi_window
);
    localparam logic [SW-1:0] LAST = SW'(SEQ_CYCLES - 1);
    localparam logic [SW-1:0] OPEN = SW'(NMI_OPEN);

    seq_state_t    nxt;
    logic [SW-1:0] seq_cnt;
    logic          from_run;
    logic          release_now;

    // Next-state decision from the current state and synchronized pin.
    always_comb begin
        nxt         = state;
        release_now = 1'b0;
        unique case (state)
            ST_RUN:  if (pin_s) nxt = ST_HALT;
            ST_HALT: begin
                if (!pin_s) begin
                    if (pulse_valid || !from_run) nxt = ST_SEQ;
                    else                          nxt = ST_RUN;
                end
            end
            ST_SEQ: begin
                if (pin_s) nxt = ST_HALT;
                else if (seq_cnt == LAST) begin
                    if (hold_req) nxt = ST_HOLD;
                    else begin
                        nxt         = ST_RUN;
                        release_now = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (pin_s) nxt = ST_HALT;
                else if (!hold_req) begin
                    nxt         = ST_RUN;
                    release_now = 1'b1;
                end
            end
            default: nxt = ST_HALT;
        endcase
    end

    // State register; a block reset looks like a pulse already counted.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    // Remembers whether the halt interrupted normal running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 from_run <= 1'b0;
        else if (nxt == ST_HALT && state != ST_HALT) from_run <= (state == ST_RUN);
    end

    // Sequence cycle counter, cleared on every entry to the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   seq_cnt <= '0;
        else if (nxt == ST_SEQ && state != ST_SEQ)    seq_cnt <= '0;
        else if (state == ST_SEQ && seq_cnt != LAST)  seq_cnt <= seq_cnt + SW'(1);
    end

    // Registered one-cycle release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= release_now;
    end

    assign pulse_first = (state != ST_HALT) && pin_s;
    assign pulse_count = (state == ST_HALT) && pin_s;
    assign nmi_window  = (state == ST_RUN) || (state == ST_HOLD) ||
                         ((state == ST_SEQ) && (seq_cnt >= OPEN));
endmodule

// File: rtl/rst_sequencer.sv
// Top of the reset sequencer: synchronizer, pulse-width check, control
// state and pin-level decode.
// Assumes: clk is the core clock; rst_n is a synchronous block reset.
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          MIN_HIGH    = 4,
    parameter int          SEQ_CYCLES  = 10,
    parameter int          NMI_OPEN    = 2,
    parameter int          ADDR_W      = 20,
    parameter logic [19:0] RESET_VEC   = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_pin,
    input  logic              hold_req,
    output logic              core_halt,
    output logic              start,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              status_oe,
    output logic              bus_oe,
    output logic              ale_low,
    output logic              hlda,
    output logic              nmi_ok
);
    seq_state_t state;
    logic pin_s, p_first, p_count, p_valid, p_first_cycle, start_q, nmi_w;

    rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(reset_pin), .q_sync(pin_s)
    );

    rst_seq_width #(.MIN_HIGH(MIN_HIGH)) u_width (
        .clk(clk), .rst_n(rst_n), .first(p_first), .count(p_count),
        .valid(p_valid), .first_cycle(p_first_cycle)
    );

    rst_seq_fsm #(.SEQ_CYCLES(SEQ_CYCLES), .NMI_OPEN(NMI_OPEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pulse_valid(p_valid),
        .hold_req(hold_req), .state(state), .pulse_first(p_first),
        .pulse_count(p_count), .start_q(start_q), .nmi_window(nmi_w)
    );

    // Pin-level decode from the control state.
    always_comb begin
        core_halt  = (state != ST_RUN);
        bus_oe     = (state == ST_RUN);
        ale_low    = (state != ST_RUN);
        hlda       = (state == ST_HOLD);
        status_oe  = (state == ST_RUN) || ((state == ST_HALT) && p_first_cycle);
        nmi_ok     = nmi_w;
        start      = start_q;
        fetch_addr = start_q ? ADDR_W'(RESET_VEC) : '0;
    end
endmodule

// File: rtl/rst_sequencer_chk.sv
// Port-level properties of the reset sequencer, bound to every instance.
// Assumes: the ports of rst_sequencer.
module rst_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic core_halt,
    input logic start,
    input logic status_oe,
    input logic bus_oe,
    input logic ale_low,
    input logic hlda
);
    // R5: release pulse lasts one cycle.
    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R4: release only follows a held core.
    p_start_after_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(core_halt));
    // R8: hold acknowledge keeps the bus floated and the strobe low.
    p_hold_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && ale_low));
    // R6: status still driven in the first halted cycle.
    p_status_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_halt) |-> status_oe);
    // R2: a held core never drives the bus.
    p_halt_floats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |-> !bus_oe);
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .start(start),
    .status_oe(status_oe), .bus_oe(bus_oe), .ale_low(ale_low), .hlda(hlda)
);

// File: tb/test_rst_sequencer.sv
// Bench: behavioural per-clock model compared with every output.
module test_rst_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_pin = 1'b1;
    logic hold_req = 1'b0;
    logic core_halt, start, status_oe, bus_oe, ale_low, hlda, nmi_ok;
    logic [19:0] fetch_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rst_sequencer i_rst_sequencer (
        .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .hold_req(hold_req),
        .core_halt(core_halt), .start(start), .fetch_addr(fetch_addr),
        .status_oe(status_oe), .bus_oe(bus_oe), .ale_low(ale_low),
        .hlda(hlda), .nmi_ok(nmi_ok)
    );

    // Reference model: mode 0 running, 1 pin held, 2 sequence, 3 hold.
    bit pin_q[$];
    int mode, highs, left;
    bit was_run, m_start;

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_q = '{1'b1, 1'b1};
            mode = 1; highs = 99; left = 0; was_run = 0; m_start = 0;
        end else begin
            bit seen;
            seen = pin_q[1];
            pin_q[1] = pin_q[0];
            pin_q[0] = reset_pin;
            m_start = 0;
            case (mode)
                0: if (seen) begin mode = 1; highs = 1; was_run = 1; end
                1: if (seen) highs++;
                   else if (highs > 4 || !was_run) begin mode = 2; left = 10; end
                   else mode = 0;
                2: if (seen) begin mode = 1; highs = 1; was_run = 0; end
                   else if (left == 1) begin
                       if (hold_req) mode = 3;
                       else begin mode = 0; m_start = 1; end
                   end else left--;
                default: if (seen) begin mode = 1; highs = 1; was_run = 0; end
                   else if (!hold_req) begin mode = 0; m_start = 1; end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_nmi;
            e_nmi = (mode == 0) || (mode == 3) || (mode == 2 && (10 - left) >= 2);
            chk("R2", "core_halt", core_halt, mode != 0);
            chk("R2", "bus_oe", bus_oe, mode == 0);
            chk("R2", "ale_low", ale_low, mode != 0);
            chk("R5", "start", start, m_start);
            checks++;
            if (fetch_addr !== (m_start ? 20'hFFFF0 : 20'h0)) begin
                failures++;
                $display("FAIL R5 fetch_addr actual=%h expected=%h", fetch_addr,
                         m_start ? 20'hFFFF0 : 20'h0);
            end
            chk("R6", "status_oe", status_oe, mode == 0 || (mode == 1 && highs == 1));
            chk("R7", "nmi_ok", nmi_ok, e_nmi);
            chk("R8", "hlda", hlda, mode == 3);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        reset_pin = 1'b1; cyc(n); reset_pin = 1'b0;
    endtask

    // Explicit point checks on top of the per-clock comparison.
    task automatic expect_halt(input string req, input bit exp);
        chk(req, "core_halt point", core_halt, exp);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        expect_halt("R10", 1'b1);                 // power-on: held
        reset_pin = 1'b0;
        cyc(16);
        expect_halt("R10", 1'b0);                 // sequence ran by itself
        // R1: pin rise shows on core_halt after two synchronizer flops.
        reset_pin = 1'b1;
        cyc(2); expect_halt("R1", 1'b0);
        cyc(1); expect_halt("R1", 1'b1);
        cyc(6); reset_pin = 1'b0;                 // valid pulse (R4)
        cyc(20);
        pulse(3); cyc(8);                         // R3 short pulse ignored
        pulse(4); cyc(8);                         // R3 boundary: 4 ignored
        pulse(5); cyc(20);                        // R4 boundary: 5 valid
        pulse(8); cyc(6); pulse(2); cyc(20);      // R9 short pulse mid-sequence
        hold_req = 1'b1;                          // R8 hold before fetch
        pulse(7); cyc(18);
        chk("R8", "hlda point", hlda, 1'b1);
        pulse(6); cyc(5);                         // R9 pulse during hold
        hold_req = 1'b0; cyc(20);
        expect_halt("R8", 1'b0);
        pulse(30); cyc(20);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule